// File: doc/BRIEF.md
# Dual-Tuning-Word Phase-Accumulator Oscillator

This block is the phase-generation core of a numerically controlled oscillator. On every enabled clock it adds one of two stored frequency tuning words to a wide phase accumulator. The synthesized frequency is therefore `word * f_clk / 2^ACC_W`. It then takes the most significant `PH_W` bits of the accumulator, adds one of four phase offsets, and registers the result as the output phase word. One offset step is `2*pi / 2^PH_W` radians.

Switching the frequency select moves between two tones without a jump in phase, because the accumulator simply continues from its current value with the new increment. Switching the phase select moves between four phase states. Together these give frequency-shift and phase-shift keying. Three controls shape the output:

- Sleep freezes the accumulator.
- The accumulator-zero control restarts it from zero.
- Clear blanks the output word while the accumulator keeps running.

The valid flag is high only when none of the three controls was active. A combinational flag reports when the selected tuning word asks for more than half the clock rate.

Top module: `nco_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `phase_word` is 0, `phase_valid` is 0 and the accumulator is 0.
- R2: On each clock edge with `step_en`=1, `sleep`=0 and `acc_zero`=0, the accumulator becomes (accumulator + selected tuning word) mod 2^ACC_W.
- R3: `freq_sel`=k selects the tuning word at `freq_words[ACC_W*k +: ACC_W]`. A change of `freq_sel` applies from the next accumulator update onward and never moves the accumulator's current value.
- R4: `phase_sel`=k selects the offset at `phase_offsets[PH_W*k +: PH_W]`. The value formed is (accumulator[ACC_W-1 -: PH_W] + offset) mod 2^PH_W.
- R5: `phase_word` is registered. After an edge it shows the value of R4 formed from the accumulator and the `phase_sel` in place before that edge.
- R6: `acc_zero`=1 at an edge sets the accumulator to 0, whatever `step_en` and `sleep` are.
- R7: `sleep`=1 at an edge (with `acc_zero`=0) leaves the accumulator unchanged.
- R8: `out_clear`=1 at an edge forces `phase_word` to 0 after that edge, while the accumulator keeps advancing.
- R9: After an edge, `phase_valid` is 1 exactly when `sleep`, `acc_zero` and `out_clear` were all 0 at that edge.
- R10: `step_en`=0 at an edge leaves the accumulator unchanged.
- R11: `tw_over_range` is 1 exactly when the currently selected tuning word is greater than 2^(ACC_W-1). With the default width that is 0x8000_0000, and that value itself is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Accumulator advance enable |
| freq_words | input | N_FREQ*ACC_W | Packed tuning words, word k at bits ACC_W*k upward |
| freq_sel | input | FSEL_W | Tuning word select |
| phase_offsets | input | N_PHASE*PH_W | Packed phase offsets, offset k at bits PH_W*k upward |
| phase_sel | input | PSEL_W | Phase offset select |
| sleep | input | 1 | Freeze accumulator, drop valid |
| acc_zero | input | 1 | Zero the accumulator, drop valid |
| out_clear | input | 1 | Force output word to zero, drop valid |
| phase_word | output | PH_W | Registered output phase |
| phase_valid | output | 1 | Output enabled flag |
| tw_over_range | output | 1 | Selected tuning word exceeds half scale |

## Verification
The first pattern uses a tuning word of 2^20 with offset 0, so the output counts up by one per cycle. A slip in the accumulator or in the output register timing then shows up as an off-by-one. Switching between increments of 1 and 3 steps shows whether a frequency change preserves phase or restarts it. Cycling through offsets up to 0xFFF checks that the select picks the right field and that the addition wraps modulo 2^PH_W. Tuning words of 0x8000_0000, 0x8000_0001 and 0xFFFF_FFFF probe the range-flag boundary and accumulator wraparound. A long random run with rare control pulses then checks that sleep, enable, zeroing and clear interact with the correct priority.

// File: rtl/nco_pkg.sv
package nco_pkg;
   // Width of a select field for n choices (at least one bit).
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/nco_tw_select.sv
module nco_tw_select #(
   parameter int ACC_W  = 32,
   parameter int N_FREQ = 2,
   localparam int FSEL_W = nco_pkg::sel_width(N_FREQ)
) (
   input  logic [N_FREQ*ACC_W-1:0] words,
   input  logic [FSEL_W-1:0]       sel,
   output logic [ACC_W-1:0]        tw,
   output logic                    over_range
);
   localparam logic [ACC_W-1:0] HALF_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

   if (N_FREQ < 1 || (N_FREQ > 1 && (1 << FSEL_W) != N_FREQ)) begin : g_bad_nfreq
      $error("nco_tw_select: N_FREQ must be 1 or a power of two");
   end

   if (N_FREQ == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign tw = words;
   end else begin : g_mux
      logic [ACC_W-1:0] word_arr [N_FREQ];
      for (genvar k = 0; k < N_FREQ; k++) begin : g_unpack
         assign word_arr[k] = words[ACC_W*k +: ACC_W];
      end
      assign tw = word_arr[sel];
   end

   assign over_range = (tw > HALF_SCALE);
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             sleep,
   input  logic             acc_zero,
   input  logic [ACC_W-1:0] tw,
   output logic [ACC_W-1:0] acc
);
   if (ACC_W < 2) begin : g_bad_accw
      $error("nco_phase_acc: ACC_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              acc <= '0;
      else if (acc_zero)       acc <= '0;
      else if (step_en && !sleep) acc <= acc + tw;
   end

   // R6
   acc_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_zero |=> (acc == '0));
   // R7
   sleep_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !acc_zero) |=> $stable(acc));
   // R10
   idle_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !acc_zero) |=> $stable(acc));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out #(
   parameter int PH_W    = 12,
   parameter int N_PHASE = 4,
   localparam int PSEL_W = nco_pkg::sel_width(N_PHASE)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PH_W-1:0]         acc_top,
   input  logic [N_PHASE*PH_W-1:0] offsets,
   input  logic [PSEL_W-1:0]       sel,
   input  logic                    sleep,
   input  logic                    acc_zero,
   input  logic                    out_clear,
   output logic [PH_W-1:0]         phase_word,
   output logic                    phase_valid
);
   if (N_PHASE < 2 || (1 << PSEL_W) != N_PHASE) begin : g_bad_nphase
      $error("nco_phase_out: N_PHASE must be a power of two, at least 2");
   end

   logic [PH_W-1:0] ofs_arr [N_PHASE];
   for (genvar k = 0; k < N_PHASE; k++) begin : g_unpack
      assign ofs_arr[k] = offsets[PH_W*k +: PH_W];
   end

   logic [PH_W-1:0] ph_sum;
   logic            blocked;
   assign ph_sum  = acc_top + ofs_arr[sel];
   assign blocked = sleep | acc_zero | out_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_word  <= '0;
         phase_valid <= 1'b0;
      end else begin
         phase_word  <= out_clear ? '0 : ph_sum;
         phase_valid <= !blocked;
      end
   end

   // R8
   clear_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_clear |=> (phase_word == '0));
   // R9
   blocked_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep || acc_zero || out_clear) |=> !phase_valid);
   // R9
   free_raises_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep || acc_zero || out_clear) |=> phase_valid);
endmodule

// File: rtl/nco_core.sv
module nco_core #(
   parameter int ACC_W   = 32,
   parameter int PH_W    = 12,
   parameter int N_FREQ  = 2,
   parameter int N_PHASE = 4,
   localparam int FSEL_W = nco_pkg::sel_width(N_FREQ),
   localparam int PSEL_W = nco_pkg::sel_width(N_PHASE)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_en,
   input  logic [N_FREQ*ACC_W-1:0] freq_words,
   input  logic [FSEL_W-1:0]       freq_sel,
   input  logic [N_PHASE*PH_W-1:0] phase_offsets,
   input  logic [PSEL_W-1:0]       phase_sel,
   input  logic                    sleep,
   input  logic                    acc_zero,
   input  logic                    out_clear,
   output logic [PH_W-1:0]         phase_word,
   output logic                    phase_valid,
   output logic                    tw_over_range
);
   if (PH_W < 1 || PH_W > ACC_W) begin : g_bad_phw
      $error("nco_core: PH_W must lie in 1..ACC_W");
   end

   logic [ACC_W-1:0] tw_sel;
   logic [ACC_W-1:0] acc;

   nco_tw_select #(.ACC_W(ACC_W), .N_FREQ(N_FREQ)) u_tw (
      .words      (freq_words),
      .sel        (freq_sel),
      .tw         (tw_sel),
      .over_range (tw_over_range)
   );

   nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .sleep    (sleep),
      .acc_zero (acc_zero),
      .tw       (tw_sel),
      .acc      (acc)
   );

   logic [PH_W-1:0]        acc_top;
   logic [ACC_W-PH_W:0]    acc_low_unused;
   assign acc_top        = acc[ACC_W-1 -: PH_W];
   assign acc_low_unused = {1'b0, acc[ACC_W-PH_W-1:0]};

   nco_phase_out #(.PH_W(PH_W), .N_PHASE(N_PHASE)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_top     (acc_top),
      .offsets     (phase_offsets),
      .sel         (phase_sel),
      .sleep       (sleep),
      .acc_zero    (acc_zero),
      .out_clear   (out_clear),
      .phase_word  (phase_word),
      .phase_valid (phase_valid)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (phase_word == '0 && !phase_valid && acc == '0));
endmodule

// File: tb/nco_core_test.sv
`timescale 1ns/1ps
module nco_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic [63:0] freq_words = '0;
   logic        freq_sel = 1'b0;
   logic [47:0] phase_offsets = '0;
   logic [1:0]  phase_sel = '0;
   logic        sleep = 1'b0;
   logic        acc_zero = 1'b0;
   logic        out_clear = 1'b0;
   logic [11:0] phase_word;
   logic        phase_valid;
   logic        tw_over_range;

   always #2.5 clk = ~clk;

   nco_core uut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .freq_words(freq_words),
      .freq_sel(freq_sel), .phase_offsets(phase_offsets), .phase_sel(phase_sel),
      .sleep(sleep), .acc_zero(acc_zero), .out_clear(out_clear),
      .phase_word(phase_word), .phase_valid(phase_valid),
      .tw_over_range(tw_over_range)
   );

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   logic [31:0] acc_m = '0;
   logic [11:0] out_m = '0;
   logic        val_m = 1'b0;

   function automatic logic [31:0] sel_word(input logic [63:0] w, input logic s);
      return w[32*s +: 32];
   endfunction

   function automatic logic [11:0] sel_ofs(input logic [47:0] o, input logic [1:0] s);
      return o[12*s +: 12];
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   // one clock: range flag, model update at the edge, outputs at the negedge
   task automatic tick();
      logic [31:0] w;
      #1;
      w = sel_word(freq_words, freq_sel);
      chk("R11 over_range", {31'd0, tw_over_range}, {31'd0, (w > 32'h8000_0000)});
      @(posedge clk);
      if (!rst_n) begin
         acc_m = '0; out_m = '0; val_m = 1'b0;
      end else begin
         out_m = out_clear ? 12'd0 : acc_m[31:20] + sel_ofs(phase_offsets, phase_sel);
         val_m = !(sleep || acc_zero || out_clear);
         if (acc_zero) acc_m = '0;
         else if (step_en && !sleep) acc_m = acc_m + w;
      end
      @(negedge clk);
      chk("R5 phase_word", {20'd0, phase_word}, {20'd0, out_m});
      chk("R9 valid", {31'd0, phase_valid}, {31'd0, val_m});
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      void'($urandom(32'd20240517));
      @(negedge clk);
      cur_req = "R1";
      run(3);
      rst_n = 1'b1;
      step_en = 1'b1;
      freq_words = {32'h0030_0000, 32'h0010_0000};
      phase_offsets = {12'hFFF, 12'h800, 12'h100, 12'h000};
      run(1);
      cur_req = "R2"; run(8);
      cur_req = "R3"; freq_sel = 1'b1; run(5); freq_sel = 1'b0; run(3);
      cur_req = "R4";
      for (int k = 0; k < 4; k++) begin
         phase_sel = 2'(k); run(3);
      end
      phase_sel = 2'd0;
      cur_req = "R10"; step_en = 1'b0; run(4); step_en = 1'b1;
      cur_req = "R7"; sleep = 1'b1; run(4); sleep = 1'b0; run(2);
      cur_req = "R8"; out_clear = 1'b1; run(4); out_clear = 1'b0; run(2);
      cur_req = "R6"; acc_zero = 1'b1; sleep = 1'b1; run(2);
      acc_zero = 1'b0; sleep = 1'b0; run(3);
      cur_req = "R11";
      freq_sel = 1'b1;
      freq_words[63:32] = 32'h8000_0000; run(3);
      freq_words[63:32] = 32'h8000_0001; run(3);
      freq_words[63:32] = 32'hFFFF_FFFF; run(4);
      freq_sel = 1'b0; run(2);
      cur_req = "R2";
      freq_words[31:0] = 32'hFFF0_0000; run(4);
      // random run mixing all inputs
      for (int i = 0; i < 3000; i++) begin
         cur_req = "R3";
         if ($urandom_range(49) == 0) freq_words = {$urandom(), $urandom()};
         if ($urandom_range(49) == 0) phase_offsets = {$urandom(), 16'($urandom())};
         if ($urandom_range(7) == 0) freq_sel = 1'($urandom());
         if ($urandom_range(7) == 0) phase_sel = 2'($urandom());
         step_en   = ($urandom_range(7) != 0);
         sleep     = ($urandom_range(19) == 0);
         acc_zero  = ($urandom_range(29) == 0);
         out_clear = ($urandom_range(19) == 0);
         rst_n     = ($urandom_range(499) != 0);
         if (!rst_n) cur_req = "R1";
         tick();
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule